// File: doc/BRIEF.md
# Address-Range Function Execution Profiler

This block sits beside a processor core and watches its program counter without touching it. Software programs a set of code windows, each given by a lowest and a highest instruction address. For every window the block keeps two saturating counters. One counts the clock cycles in which a valid PC lies inside the window. The other counts how many times execution moves into the window from outside. Together they give both the time spent in a function and the number of times it was called. Windows may overlap or nest, and each window counts on its own.

Each window has a small tracker state machine with two states, OUTSIDE and INSIDE. The ENTER transition goes from OUTSIDE to INSIDE when a valid PC falls in range, and this transition is what the entry counter counts. The LEAVE transition goes from INSIDE to OUTSIDE when a valid PC falls out of range. In every other case the tracker takes HOLD and keeps its state, which includes every cycle in which the PC strobe is low. A register port sets the bounds, turns counting on and off, clears all counters at once and reads results back. The 64-bit time count is read as two words, and a per-window overflow flag records saturation.

Top module: `pc_span_profiler`

## Requirements
- R1: After reset, enable is 0, every overflow flag is 0, every counter is 0, every low bound reads all ones and every high bound reads 0, so no window matches any PC.
- R2: A window matches when the PC strobe is high and low ≤ PC ≤ high, with both ends inclusive. While the block is enabled, the window's time counter adds one on each clock edge at which it matches.
- R3: A window whose low bound is greater than its high bound never matches and never counts.
- R4: The entry counter adds one on an ENTER transition, when a valid PC comes into range while the tracker is OUTSIDE. A cycle with the strobe low neither counts nor changes the tracker state.
- R5: Several windows that match the same PC (nested or overlapping ranges) each count independently.
- R6: With enable at 0 no counter changes. The trackers keep following the PC, so turning enable on while the PC is already inside a window adds no entry.
- R7: A write to the clear register zeroes every counter and every overflow flag at that clock edge. The clear takes priority over an increment in the same cycle. It does not reset the trackers, so an ENTER in that same cycle is consumed and is not counted.
- R8: Counters saturate at their all-ones value. An increment attempted at saturation sets the window's overflow flag. The flag stays set until a clear, and window i's flag is bit i of the status register.
- R9: Reading a window's time-low word returns bits [DATA_W-1:0] of its time counter and copies the upper bits into one shared snapshot. Reading a time-high word returns that snapshot, not the live counter.
- R10: Register map, with byte addresses and word-aligned access only: 0x000 control (bit 0 = enable, read/write); 0x004 clear (write-only); 0x008 status (overflow flags). Window i occupies base 0x100 + 0x20·i, with offsets +0x0 low bound, +0x4 high bound, +0x8 entry count, +0xC time low word and +0x10 time high word. Unmapped or misaligned reads return 0. Read data appears on reg_rdata after the clock edge that samples reg_rd and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pc_valid | input | 1 | Program counter strobe; high when pc carries a retired fetch address |
| pc | input | PC_W | Observed program counter |
| reg_rd | input | 1 | Register read request |
| reg_wr | input | 1 | Register write request |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Registered read data |

## Verification
The clear register can be written in the very cycle in which a window both counts a cycle and takes its ENTER transition. The bench provokes this by moving the PC from outside into a window at the same negative edge that raises the clear write. It then holds the PC inside for two more edges. The expected result is an entry count of 0 and a time count of 2: the clear wins, and the entry it swallowed is not replayed. A second collision comes from the time-low read, which can fall in the same cycle as a carry into the upper bits. The bench checks this with a narrow-data instance whose high word changes between the two reads.

// File: rtl/prof_pkg.sv
package prof_pkg;

    typedef enum logic {
        SEG_OUTSIDE = 1'b0,
        SEG_INSIDE  = 1'b1
    } seg_state_e;

    // register byte addresses
    localparam int unsigned REG_CTRL   = 'h000;
    localparam int unsigned REG_CLEAR  = 'h004;
    localparam int unsigned REG_STATUS = 'h008;
    localparam int unsigned SEG_BASE   = 'h100;
    localparam int unsigned SEG_LG     = 5;      // 32-byte window per segment

    // word offsets inside a segment window
    localparam logic [2:0] OFF_LO   = 3'd0;
    localparam logic [2:0] OFF_HI   = 3'd1;
    localparam logic [2:0] OFF_HITS = 3'd2;
    localparam logic [2:0] OFF_TLO  = 3'd3;
    localparam logic [2:0] OFF_THI  = 3'd4;

endpackage

// File: rtl/seg_tracker.sv
module seg_tracker
    import prof_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] pc,
    input  logic            pc_valid,
    input  logic [PC_W-1:0] lo,
    input  logic [PC_W-1:0] hi,
    output logic            in_range,
    output logic            entry
);

    seg_state_e state_q, state_d;
    logic       match;

    assign match = pc_valid && (pc >= lo) && (pc <= hi);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEG_OUTSIDE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEG_OUTSIDE: if (match)              state_d = SEG_INSIDE;
            SEG_INSIDE:  if (pc_valid && !match) state_d = SEG_OUTSIDE;
            default:                             state_d = SEG_OUTSIDE;
        endcase
    end

    always_comb begin
        in_range = match;
        entry    = 1'b0;
        unique case (state_q)
            SEG_OUTSIDE: entry = match;
            SEG_INSIDE:  entry = 1'b0;
            default:     entry = 1'b0;
        endcase
    end

    // R4
    enter_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        entry |=> (state_q == SEG_INSIDE));

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pc_valid |=> $stable(state_q));

endmodule

// File: rtl/seg_counters.sv
module seg_counters #(
    parameter int HIT_W  = 32,
    parameter int TIME_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              hit_inc,
    input  logic              time_inc,
    output logic [HIT_W-1:0]  hit_q,
    output logic [TIME_W-1:0] time_q,
    output logic              ovf_q
);

    localparam logic [HIT_W-1:0]  HIT_MAX  = {HIT_W{1'b1}};
    localparam logic [TIME_W-1:0] TIME_MAX = {TIME_W{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hit_q  <= '0;
            time_q <= '0;
            ovf_q  <= 1'b0;
        end else if (clr) begin
            hit_q  <= '0;
            time_q <= '0;
            ovf_q  <= 1'b0;
        end else begin
            if (hit_inc) begin
                if (hit_q == HIT_MAX) ovf_q <= 1'b1;
                else                  hit_q <= hit_q + 1'b1;
            end
            if (time_inc) begin
                if (time_q == TIME_MAX) ovf_q  <= 1'b1;
                else                    time_q <= time_q + 1'b1;
            end
        end
    end

    // R7
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (hit_q == '0 && time_q == '0 && !ovf_q));

    // R8
    hit_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_q == HIT_MAX && !clr) |=> (hit_q == HIT_MAX));

    // R8
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !clr) |=> ovf_q);

    // R6
    time_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!time_inc && !clr) |=> $stable(time_q));

endmodule

// File: rtl/prof_regfile.sv
module prof_regfile
    import prof_pkg::*;
#(
    parameter int NSEG   = 20,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int PC_W   = 32,
    parameter int HIT_W  = 32,
    parameter int TIME_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              en,
    output logic              clr,
    output logic [PC_W-1:0]   lo_q   [NSEG],
    output logic [PC_W-1:0]   hi_q   [NSEG],
    input  logic [HIT_W-1:0]  hit_q  [NSEG],
    input  logic [TIME_W-1:0] time_q [NSEG],
    input  logic [NSEG-1:0]   ovf
);

    localparam int IDX_W = $clog2(NSEG);
    localparam int HI_W  = TIME_W - DATA_W;

    logic [ADDR_W-1:0] rel;
    logic [ADDR_W-1:0] seg_num;
    logic [IDX_W-1:0]  sidx;
    logic [2:0]        off;
    logic              aligned, seg_hit;
    logic [DATA_W-1:0] rd_val;
    logic [HI_W-1:0]   snap_q;

    assign aligned = (addr[1:0] == 2'b00);
    assign rel     = addr - ADDR_W'(SEG_BASE);
    assign seg_num = rel >> SEG_LG;
    assign seg_hit = aligned && (addr >= ADDR_W'(SEG_BASE)) && (seg_num < ADDR_W'(NSEG));
    assign sidx    = IDX_W'(seg_num);
    assign off     = rel[4:2];
    assign clr     = wr && (addr == ADDR_W'(REG_CLEAR));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                 en <= 1'b0;
        else if (wr && addr == ADDR_W'(REG_CTRL))   en <= wdata[0];
    end

    for (genvar g = 0; g < NSEG; g++) begin : g_bound
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lo_q[g] <= {PC_W{1'b1}};
                hi_q[g] <= '0;
            end else if (wr && seg_hit && sidx == IDX_W'(g)) begin
                if (off == OFF_LO) lo_q[g] <= wdata[PC_W-1:0];
                if (off == OFF_HI) hi_q[g] <= wdata[PC_W-1:0];
            end
        end
    end

    always_comb begin
        rd_val = '0;
        if (addr == ADDR_W'(REG_CTRL)) begin
            rd_val[0] = en;
        end else if (addr == ADDR_W'(REG_STATUS)) begin
            rd_val[NSEG-1:0] = ovf;
        end else if (seg_hit) begin
            case (off)
                OFF_LO:   rd_val[PC_W-1:0]  = lo_q[sidx];
                OFF_HI:   rd_val[PC_W-1:0]  = hi_q[sidx];
                OFF_HITS: rd_val[HIT_W-1:0] = hit_q[sidx];
                OFF_TLO:  rd_val            = time_q[sidx][DATA_W-1:0];
                OFF_THI:  rd_val[HI_W-1:0]  = snap_q;
                default:  rd_val            = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata  <= '0;
            snap_q <= '0;
        end else if (rd) begin
            rdata <= rd_val;
            if (seg_hit && off == OFF_TLO) snap_q <= time_q[sidx][TIME_W-1:DATA_W];
        end
    end

    // R9
    snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd && seg_hit && off == OFF_TLO) |=> $stable(snap_q));

endmodule

// File: rtl/pc_span_profiler.sv
module pc_span_profiler #(
    parameter int NSEG   = 20,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int PC_W   = 32,
    parameter int HIT_W  = 32,
    parameter int TIME_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pc_valid,
    input  logic [PC_W-1:0]   pc,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata
);

    logic              en, clr;
    logic [PC_W-1:0]   lo_q   [NSEG];
    logic [PC_W-1:0]   hi_q   [NSEG];
    logic [HIT_W-1:0]  hit_q  [NSEG];
    logic [TIME_W-1:0] time_q [NSEG];
    logic [NSEG-1:0]   ovf;

    prof_regfile #(
        .NSEG(NSEG), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .PC_W(PC_W), .HIT_W(HIT_W), .TIME_W(TIME_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .rd(reg_rd), .wr(reg_wr),
        .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata),
        .en(en), .clr(clr), .lo_q(lo_q), .hi_q(hi_q),
        .hit_q(hit_q), .time_q(time_q), .ovf(ovf)
    );

    for (genvar g = 0; g < NSEG; g++) begin : g_seg
        logic inr, ent;

        seg_tracker #(.PC_W(PC_W)) u_trk (
            .clk(clk), .rst_n(rst_n), .pc(pc), .pc_valid(pc_valid),
            .lo(lo_q[g]), .hi(hi_q[g]), .in_range(inr), .entry(ent)
        );

        seg_counters #(.HIT_W(HIT_W), .TIME_W(TIME_W)) u_cnt (
            .clk(clk), .rst_n(rst_n), .clr(clr),
            .hit_inc(en && ent), .time_inc(en && inr),
            .hit_q(hit_q[g]), .time_q(time_q[g]), .ovf_q(ovf[g])
        );

        // R2
        time_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !clr |=> (time_q[g] == $past(time_q[g]) || time_q[g] == $past(time_q[g]) + 1'b1));
    end

endmodule

// File: tb/sim_pc_span_profiler.sv
module sim_pc_span_profiler;

    logic clk = 1'b0;
    always #10 clk = ~clk;
    logic rst_n;

    int n_run  = 0;
    int n_fail = 0;

    logic        a_valid, a_rd, a_wr;
    logic [31:0] a_pc, a_wdata, a_rdata;
    logic [15:0] a_addr;
    logic        b_valid, b_rd, b_wr;
    logic [7:0]  b_pc, b_wdata, b_rdata;
    logic [15:0] b_addr;

    pc_span_profiler u0 (
        .clk(clk), .rst_n(rst_n), .pc_valid(a_valid), .pc(a_pc),
        .reg_rd(a_rd), .reg_wr(a_wr), .reg_addr(a_addr),
        .reg_wdata(a_wdata), .reg_rdata(a_rdata)
    );

    pc_span_profiler #(
        .NSEG(2), .ADDR_W(16), .DATA_W(8), .PC_W(8), .HIT_W(3), .TIME_W(10)
    ) u1 (
        .clk(clk), .rst_n(rst_n), .pc_valid(b_valid), .pc(b_pc),
        .reg_rd(b_rd), .reg_wr(b_wr), .reg_addr(b_addr),
        .reg_wdata(b_wdata), .reg_rdata(b_rdata)
    );

    function automatic logic [15:0] sa(int seg, int off);
        return 16'(32'h100 + seg * 32 + off);
    endfunction

    task automatic chk(string req, string what, longint unsigned got, longint unsigned exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, got, exp);
        end
    endtask

    task automatic bus_wr(bit d, logic [15:0] adr, logic [31:0] dat);
        @(negedge clk);
        if (!d) begin a_wr = 1'b1; a_addr = adr; a_wdata = dat; end
        else    begin b_wr = 1'b1; b_addr = adr; b_wdata = dat[7:0]; end
        @(negedge clk);
        a_wr = 1'b0; b_wr = 1'b0;
    endtask

    task automatic bus_rd(bit d, logic [15:0] adr, output longint unsigned v);
        @(negedge clk);
        if (!d) begin a_rd = 1'b1; a_addr = adr; end
        else    begin b_rd = 1'b1; b_addr = adr; end
        @(negedge clk);
        a_rd = 1'b0; b_rd = 1'b0;
        v = d ? longint'(b_rdata) : longint'(a_rdata);
    endtask

    task automatic run_pc(bit d, logic [31:0] pcv, int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (!d) begin a_pc = pcv; a_valid = 1'b1; end
            else    begin b_pc = pcv[7:0]; b_valid = 1'b1; end
        end
        @(negedge clk);
        a_valid = 1'b0; b_valid = 1'b0;
    endtask

    task automatic set_seg(bit d, int seg, logic [31:0] lo, logic [31:0] hi);
        bus_wr(d, sa(seg, 'h0), lo);
        bus_wr(d, sa(seg, 'h4), hi);
    endtask

    task automatic expect_seg(bit d, int seg, string req, longint unsigned hits, longint unsigned tlo);
        longint unsigned v;
        bus_rd(d, sa(seg, 'h8), v);  chk(req, $sformatf("seg%0d hits", seg), v, hits);
        bus_rd(d, sa(seg, 'hC), v);  chk(req, $sformatf("seg%0d time_lo", seg), v, tlo);
    endtask

    task automatic t_reset();
        longint unsigned v;
        bus_rd(0, 16'h000, v);      chk("R1", "ctrl", v, 0);
        bus_rd(0, 16'h008, v);      chk("R1", "status", v, 0);
        bus_rd(0, sa(0, 'h0), v);   chk("R1", "lo bound", v, 64'hFFFF_FFFF);
        bus_rd(0, sa(0, 'h4), v);   chk("R1", "hi bound", v, 0);
        bus_rd(1, sa(1, 'h0), v);   chk("R1", "narrow lo bound", v, 64'hFF);
        run_pc(0, 32'h0, 3);
        expect_seg(0, 0, "R1", 0, 0);
    endtask

    task automatic t_basic();
        set_seg(0, 0, 32'h100, 32'h1FF);
        run_pc(0, 32'h150, 5);
        run_pc(0, 32'h300, 2);
        run_pc(0, 32'h180, 3);
        expect_seg(0, 0, "R2", 2, 8);
    endtask

    task automatic t_bounds();
        set_seg(0, 1, 32'h200, 32'h20F);
        run_pc(0, 32'h200, 1);
        run_pc(0, 32'h210, 1);
        run_pc(0, 32'h20F, 1);
        expect_seg(0, 1, "R2", 2, 2);
    endtask

    task automatic t_inverted();
        set_seg(0, 2, 32'h400, 32'h3FF);
        run_pc(0, 32'h400, 3);
        run_pc(0, 32'h3FF, 2);
        expect_seg(0, 2, "R3", 0, 0);
    endtask

    task automatic t_nested();
        set_seg(0, 3, 32'h1000, 32'h1FFF);
        set_seg(0, 4, 32'h1100, 32'h11FF);
        run_pc(0, 32'h1050, 2);
        run_pc(0, 32'h1150, 3);
        run_pc(0, 32'h1050, 1);
        expect_seg(0, 3, "R5", 1, 6);
        expect_seg(0, 4, "R5", 1, 3);
    endtask

    task automatic t_valid();
        set_seg(0, 5, 32'h500, 32'h5FF);
        run_pc(0, 32'h510, 2);
        repeat (3) begin @(negedge clk); a_pc = 32'h900; a_valid = 1'b0; end
        run_pc(0, 32'h520, 2);
        expect_seg(0, 5, "R4", 1, 4);
    endtask

    task automatic t_enable();
        bus_wr(0, 16'h000, 0);
        bus_wr(0, 16'h004, 0);
        run_pc(0, 32'h700, 1);
        run_pc(0, 32'h510, 4);
        expect_seg(0, 5, "R6", 0, 0);
        bus_wr(0, 16'h000, 1);
        run_pc(0, 32'h520, 3);
        expect_seg(0, 5, "R6", 0, 3);
    endtask

    task automatic t_clear_collide();
        run_pc(0, 32'h300, 1);
        @(negedge clk);
        a_pc = 32'h120; a_valid = 1'b1; a_wr = 1'b1; a_addr = 16'h004; a_wdata = 0;
        @(negedge clk);
        a_wr = 1'b0;
        @(negedge clk);
        @(negedge clk);
        a_valid = 1'b0;
        expect_seg(0, 0, "R7", 0, 2);
        expect_seg(0, 3, "R7", 0, 0);
    endtask

    task automatic t_map();
        longint unsigned v;
        bus_wr(0, sa(19, 'h0), 32'h0000_ABCD);
        bus_rd(0, sa(19, 'h0), v);      chk("R10", "seg19 lo readback", v, 32'hABCD);
        bus_rd(0, 16'h000, v);          chk("R10", "ctrl readback", v, 1);
        bus_rd(0, sa(0, 'h14), v);      chk("R10", "unmapped offset", v, 0);
        bus_rd(0, sa(0, 'h1), v);       chk("R10", "misaligned read", v, 0);
    endtask

    task automatic t_snapshot();
        longint unsigned v;
        bus_wr(1, 16'h000, 1);
        set_seg(1, 0, 32'h10, 32'h1F);
        run_pc(1, 32'h10, 250);
        bus_rd(1, sa(0, 'hC), v);   chk("R9", "time lo at 250", v, 8'hFA);
        bus_rd(1, sa(0, 'h10), v);  chk("R9", "time hi at 250", v, 0);
        run_pc(1, 32'h10, 20);
        bus_rd(1, sa(0, 'h10), v);  chk("R9", "stale snapshot", v, 0);
        bus_rd(1, sa(0, 'hC), v);   chk("R9", "time lo at 270", v, 8'h0E);
        bus_rd(1, sa(0, 'h10), v);  chk("R9", "time hi at 270", v, 1);
    endtask

    task automatic t_time_sat();
        longint unsigned v;
        bus_wr(1, 16'h004, 0);
        run_pc(1, 32'h10, 1030);
        bus_rd(1, sa(0, 'hC), v);   chk("R8", "time lo saturated", v, 8'hFF);
        bus_rd(1, sa(0, 'h10), v);  chk("R8", "time hi saturated", v, 3);
        bus_rd(1, 16'h008, v);      chk("R8", "status after time sat", v, 1);
    endtask

    task automatic t_hit_sat();
        longint unsigned v;
        bus_wr(1, 16'h004, 0);
        set_seg(1, 1, 32'h40, 32'h40);
        for (int k = 0; k < 10; k++) begin
            run_pc(1, 32'h40, 1);
            run_pc(1, 32'h41, 1);
        end
        expect_seg(1, 1, "R8", 7, 10);
        bus_rd(1, 16'h008, v);      chk("R8", "status after hit sat", v, 2);
        bus_wr(1, 16'h004, 0);
        bus_rd(1, 16'h008, v);      chk("R7", "status after clear", v, 0);
        bus_rd(1, sa(1, 'h8), v);   chk("R7", "hits after clear", v, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R10 watchdog: actual=timeout expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        a_valid = 1'b0; a_rd = 1'b0; a_wr = 1'b0; a_pc = '0; a_wdata = '0; a_addr = '0;
        b_valid = 1'b0; b_rd = 1'b0; b_wr = 1'b0; b_pc = '0; b_wdata = '0; b_addr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        bus_wr(0, 16'h000, 1);
        t_basic();
        t_bounds();
        t_inverted();
        t_nested();
        t_valid();
        t_enable();
        t_clear_collide();
        t_map();
        t_snapshot();
        t_time_sat();
        t_hit_sat();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule